// File: doc/BRIEF.md
# Complex Sub-Block Multiply-Accumulate Engine

This block is a compute engine for blocked matrix products. It keeps one square K×K sub-block for each of three operands in local registers: two source blocks A and B, and an accumulator block C. A small command set drives it. Two commands load A or B from an input stream. One streams C out. One clears C. One performs C += A·B. Every element is a complex fixed-point value with signed 16-bit real and imaginary parts.

Stream transfers and arithmetic are run by two separate state machines, so a load can continue while C is being cleared. The product uses P complex multipliers. In each cycle one A element is broadcast to all P multipliers, and each multiplier updates a different C element, so no adder tree is needed. The datapath has two stages. Stage one forms the complex products. Stage two adds them into C. Interlocks hold back any command whose buffer is in use by the other machine.

Top module: `cplx_blk_mac`

## Requirements
- R1: After reset, in_ready and out_valid are low and every element of C reads as zero.
- R2: cmd_op codes are 0 = load A, 1 = load B, 2 = store C, 3 = clear C, 4 = multiply-accumulate. Codes 5 to 7 are accepted in one handshake and change no state.
- R3: A load takes K·K input beats, one per in_valid/in_ready handshake, in row-major order. Element (r,s) arrives as beat r·K+s, with its real part in in_data[31:16] and its imaginary part in in_data[15:0]. in_ready is high only while a load is in progress.
- R4: A store sends K·K beats of C in row-major order, using the same field layout as R3. out_last is high on the final beat only. out_data and out_valid stay steady while out_ready is low.
- R5: Clear sets every C element to zero in one cycle. It is accepted while a load of A or B is in progress.
- R6: Multiply-accumulate performs C[r][s] += Σt m(A[r][t], B[t][s]). The real part of m(x,y) is the low 16 bits of (xr·yr − xi·yi) shifted arithmetically right by FRAC (default 4). The imaginary part is the low 16 bits of (xr·yi + xi·yr) shifted the same way. Every addition wraps modulo 2^16 with no saturation.
- R7: Repeated multiply-accumulate commands without a clear add into the existing contents of C.
- R8: While a multiply-accumulate is running, every load, store, clear and multiply-accumulate command is held with cmd_ready low. A multiply-accumulate is held while any transfer is in progress. A clear is held while a store is in progress.
- R9: An accepted multiply-accumulate keeps the compute machine busy for exactly K³/P + 1 cycles. A held command is accepted in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (R2) |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| in_valid | input | 1 | Input element offered |
| in_data | input | 32 | Input element, real part high, imaginary part low |
| in_ready | output | 1 | Engine takes an input element |
| out_valid | output | 1 | Output element offered |
| out_data | output | 32 | Output element of C |
| out_ready | input | 1 | Downstream takes the output element |
| out_last | output | 1 | Final element of a store |

## Verification
The bench compares every stored beat against a reference model. Stores run under irregular backpressure, which would expose a design that advances its index without a handshake or loses out_last. Operand values are large enough to overflow, so a design that saturates or skips the FRAC shift gives wrong sums. A second multiply-accumulate without a clear catches a design that overwrites C instead of adding into it. The bench counts the exact stall length after a multiply-accumulate, which exposes a missing or extra pipeline stage. It also tries a load during a multiply-accumulate, a multiply-accumulate during a load, and a clear during a store. A design that let any of these through would corrupt the operands or the streamed C.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
   typedef enum logic [2:0] {
      OP_LDA  = 3'd0,
      OP_LDB  = 3'd1,
      OP_STC  = 3'd2,
      OP_ZERO = 3'd3,
      OP_MAC  = 3'd4
   } op_e;

   typedef enum logic [1:0] {
      XF_IDLE,
      XF_LDA,
      XF_LDB,
      XF_STC
   } xf_e;
endpackage

// File: rtl/cbm_cmul.sv
`timescale 1ns/1ps
// One complex multiplier: four real products, a subtract and an add,
// then a fixed-point rescale that keeps the low W bits.
module cbm_cmul #(
   parameter int W    = 16,
   parameter int FRAC = 4
) (
   input  logic [2*W-1:0] x,
   input  logic [2*W-1:0] y,
   output logic [2*W-1:0] z
);
   localparam int FW = 2*W + 1;

   logic signed [W-1:0]  xr, xi, yr, yi;
   logic signed [FW-1:0] xr_e, xi_e, yr_e, yi_e;
   logic signed [FW-1:0] fr, fi;

   assign xr = x[2*W-1:W];
   assign xi = x[W-1:0];
   assign yr = y[2*W-1:W];
   assign yi = y[W-1:0];
   assign xr_e = FW'(xr);
   assign xi_e = FW'(xi);
   assign yr_e = FW'(yr);
   assign yi_e = FW'(yi);
   assign fr = xr_e * yr_e - xi_e * yi_e;
   assign fi = xr_e * yi_e + xi_e * yr_e;

   generate
      if (FRAC == 0) begin : g_int
         assign z = {fr[W-1:0], fi[W-1:0]};
      end else begin : g_frac
         logic signed [FW-1:0] sr, si;
         assign sr = fr >>> FRAC;
         assign si = fi >>> FRAC;
         assign z  = {sr[W-1:0], si[W-1:0]};
      end
   endgenerate
endmodule

// File: rtl/cbm_xfer.sv
`timescale 1ns/1ps
// Transfer machine: streams A or B in, streams C out.
module cbm_xfer
   import cbm_pkg::*;
#(
   parameter int W = 16,
   parameter int N = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_lda,
   input  logic                     start_ldb,
   input  logic                     start_stc,
   input  logic                     in_valid,
   input  logic [2*W-1:0]           in_data,
   output logic                     in_ready,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [2*W-1:0]           out_data,
   output logic                     out_last,
   input  logic [N-1:0][2*W-1:0]    c_in,
   output logic [N-1:0][2*W-1:0]    a_out,
   output logic [N-1:0][2*W-1:0]    b_out,
   output logic                     idle,
   output logic                     storing
);
   localparam int IW = $clog2(N);

   xf_e                   st;
   logic [IW-1:0]         idx;
   logic [N-1:0][2*W-1:0] a_q, b_q;
   logic                  beat;

   assign in_ready  = (st == XF_LDA) || (st == XF_LDB);
   assign out_valid = (st == XF_STC);
   assign out_data  = c_in[idx];
   assign out_last  = out_valid && (idx == IW'(N-1));
   assign beat      = (in_valid && in_ready) || (out_valid && out_ready);
   assign idle      = (st == XF_IDLE);
   assign storing   = (st == XF_STC);
   assign a_out     = a_q;
   assign b_out     = b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= XF_IDLE;
         idx <= '0;
      end else if (st == XF_IDLE) begin
         idx <= '0;
         if (start_lda)      st <= XF_LDA;
         else if (start_ldb) st <= XF_LDB;
         else if (start_stc) st <= XF_STC;
      end else if (beat) begin
         if (idx == IW'(N-1)) begin
            idx <= '0;
            st  <= XF_IDLE;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
      end else if (in_valid && in_ready) begin
         if (st == XF_LDA) a_q[idx] <= in_data;
         else              b_q[idx] <= in_data;
      end
   end

   // A held output element must not move (C is frozen during a store).
   p_store_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("store beat changed while held");

   // The flagged beat ends the store.
   p_last_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid)
      else $error("store continued past last beat");
endmodule

// File: rtl/cbm_comp.sv
`timescale 1ns/1ps
// Compute machine: clear and the two-stage broadcast multiply-accumulate.
// Loop order: i outer, row j, column group kb; A[j][i] is broadcast and
// the P multipliers cover B[i][kb*P+q] -> C[j][kb*P+q].
module cbm_comp #(
   parameter int W    = 16,
   parameter int K    = 8,
   parameter int P    = 4,
   parameter int FRAC = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      go_zero,
   input  logic                      go_mac,
   input  logic [K*K-1:0][2*W-1:0]   a_in,
   input  logic [K*K-1:0][2*W-1:0]   b_in,
   output logic [K*K-1:0][2*W-1:0]   c_out,
   output logic                      busy
);
   localparam int N  = K*K;
   localparam int EW = 2*W;
   localparam int IW = $clog2(N);
   localparam int KW = $clog2(K);
   localparam int KB = K / P;
   localparam int BW = (KB > 1) ? $clog2(KB) : 1;

   logic                 run, v1;
   logic [KW-1:0]        ri, rj;
   logic [BW-1:0]        rkb;
   logic [IW-1:0]        a_idx, b_base, c_base, c1;
   logic [P-1:0][EW-1:0] prod, p1;
   logic [N-1:0][EW-1:0] c_q;

   function automatic logic [EW-1:0] cadd(input logic [EW-1:0] x,
                                          input logic [EW-1:0] y);
      logic [W-1:0] re, im;
      re = x[EW-1:W] + y[EW-1:W];
      im = x[W-1:0] + y[W-1:0];
      return {re, im};
   endfunction

   assign a_idx  = IW'(int'(rj) * K + int'(ri));
   assign b_base = IW'(int'(ri) * K + int'(rkb) * P);
   assign c_base = IW'(int'(rj) * K + int'(rkb) * P);
   assign busy   = run || v1;
   assign c_out  = c_q;

   // Stage 1: P complex multipliers sharing one broadcast operand.
   generate
      for (genvar q = 0; q < P; q++) begin : g_mul
         cbm_cmul #(.W(W), .FRAC(FRAC)) u_mul (
            .x(a_in[a_idx]),
            .y(b_in[b_base + IW'(q)]),
            .z(prod[q])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         ri  <= '0;
         rj  <= '0;
         rkb <= '0;
      end else if (go_mac) begin
         run <= 1'b1;
         ri  <= '0;
         rj  <= '0;
         rkb <= '0;
      end else if (run) begin
         if (rkb == BW'(KB-1)) begin
            rkb <= '0;
            if (rj == KW'(K-1)) begin
               rj <= '0;
               if (ri == KW'(K-1)) begin
                  ri  <= '0;
                  run <= 1'b0;
               end else begin
                  ri <= ri + 1'b1;
               end
            end else begin
               rj <= rj + 1'b1;
            end
         end else begin
            rkb <= rkb + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1 <= 1'b0;
         p1 <= '0;
         c1 <= '0;
      end else begin
         v1 <= run;
         if (run) begin
            p1 <= prod;
            c1 <= c_base;
         end
      end
   end

   // Stage 2: read-modify-write of P distinct C elements in one cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= '0;
      end else if (go_zero) begin
         c_q <= '0;
      end else if (v1) begin
         for (int q = 0; q < P; q++)
            c_q[c1 + IW'(q)] <= cadd(c_q[c1 + IW'(q)], p1[q]);
      end
   end

   // C only moves under clear or an active pipeline.
   p_c_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !go_zero) |=> $stable(c_q))
      else $error("C changed with no command");

   p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      go_zero |=> (c_q == '0))
      else $error("clear left nonzero C");

   // Stage 2 always follows an issue cycle.
   p_stage2_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run) |-> v1)
      else $error("pipeline lost final issue");
endmodule

// File: rtl/cplx_blk_mac.sv
`timescale 1ns/1ps
module cplx_blk_mac
   import cbm_pkg::*;
#(
   parameter int W    = 16,
   parameter int K    = 8,
   parameter int P    = 4,
   parameter int FRAC = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cmd_valid,
   input  logic [2:0]     cmd_op,
   output logic           cmd_ready,
   input  logic           in_valid,
   input  logic [2*W-1:0] in_data,
   output logic           in_ready,
   output logic           out_valid,
   output logic [2*W-1:0] out_data,
   input  logic           out_ready,
   output logic           out_last
);
   localparam int N = K*K;

   generate
      if (K % P != 0) begin : g_bad_unroll
         $error("K must be a multiple of P");
      end
      if (K < 2 || P < 1) begin : g_bad_size
         $error("K must be at least 2 and P at least 1");
      end
      if (FRAC >= W) begin : g_bad_frac
         $error("FRAC must be below W");
      end
   endgenerate

   op_e                   op;
   logic                  ok, acc;
   logic                  xf_idle, xf_storing, c_busy;
   logic [N-1:0][2*W-1:0] a_w, b_w, c_w;

   assign op = op_e'(cmd_op);

   always_comb begin
      unique case (op)
         OP_LDA, OP_LDB, OP_STC: ok = xf_idle && !c_busy;
         OP_ZERO:                ok = !c_busy && !xf_storing;
         OP_MAC:                 ok = xf_idle && !c_busy;
         default:                ok = 1'b1;
      endcase
   end

   assign cmd_ready = ok;
   assign acc       = cmd_valid && ok;

   cbm_xfer #(.W(W), .N(N)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_lda (acc && op == OP_LDA),
      .start_ldb (acc && op == OP_LDB),
      .start_stc (acc && op == OP_STC),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_last  (out_last),
      .c_in      (c_w),
      .a_out     (a_w),
      .b_out     (b_w),
      .idle      (xf_idle),
      .storing   (xf_storing)
   );

   cbm_comp #(.W(W), .K(K), .P(P), .FRAC(FRAC)) u_comp (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_zero (acc && op == OP_ZERO),
      .go_mac  (acc && op == OP_MAC),
      .a_in    (a_w),
      .b_in    (b_w),
      .c_out   (c_w),
      .busy    (c_busy)
   );

   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      c_busy |-> xf_idle)
      else $error("transfer ran during multiply-accumulate");

   p_mac_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && c_busy && cmd_op <= 3'd4) |-> !cmd_ready)
      else $error("command taken during multiply-accumulate");

   p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid))
      else $error("load and store active together");
endmodule

// File: tb/sim_cplx_blk_mac.sv
`timescale 1ns/1ps
module sim_cplx_blk_mac;
   localparam int K  = 8;
   localparam int P  = 4;
   localparam int FR = 4;
   localparam int N  = K*K;

   typedef struct packed {
      logic [31:0] d;
      logic        last;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [2:0]  cmd_op = 3'd0;
   logic        cmd_ready;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [31:0] out_data;
   logic        out_ready = 1'b0;
   logic        out_last;

   int          checks = 0;
   int          errors = 0;
   string       cur_tag = "R1";
   logic        loading = 1'b0;
   int          bp_cnt = 0;
   exp_t        q[$];
   logic [31:0] ma [N];
   logic [31:0] mb [N];
   logic [31:0] mc [N];

   always #2 clk = ~clk;

   cplx_blk_mac #(.W(16), .K(K), .P(P), .FRAC(FR)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_ready(cmd_ready), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .out_last(out_last)
   );

   task automatic chk(input bit good, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!good) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_mul(input logic [31:0] x, input logic [31:0] y);
      logic signed [32:0] fr, fi, sr, si;
      fr = 33'(signed'(x[31:16])) * 33'(signed'(y[31:16]))
         - 33'(signed'(x[15:0])) * 33'(signed'(y[15:0]));
      fi = 33'(signed'(x[31:16])) * 33'(signed'(y[15:0]))
         + 33'(signed'(x[15:0])) * 33'(signed'(y[31:16]));
      sr = fr >>> FR;
      si = fi >>> FR;
      return {sr[15:0], si[15:0]};
   endfunction

   function automatic logic [31:0] m_add(input logic [31:0] x, input logic [31:0] y);
      logic [15:0] re, im;
      re = x[31:16] + y[31:16];
      im = x[15:0] + y[15:0];
      return {re, im};
   endfunction

   function automatic logic [31:0] pat(input int n, input int s);
      return {16'(n*1237 + s*9001 + 5), 16'(s*311 - n*2053)};
   endfunction

   task automatic model_mac();
      for (int r = 0; r < K; r++)
         for (int c = 0; c < K; c++)
            for (int t = 0; t < K; t++)
               mc[r*K+c] = m_add(mc[r*K+c], m_mul(ma[r*K+t], mb[t*K+c]));
   endtask

   task automatic issue(input logic [2:0] op);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      #1;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 cmd_valid = 1'b0;
   endtask

   task automatic push_beats(input logic [2:0] op, input int seed);
      for (int n = 0; n < N; n++) begin
         logic [31:0] d;
         d = pat(n, seed);
         if (op == 3'd0) ma[n] = d;
         else            mb[n] = d;
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = d;
         #1;
         while (!in_ready) begin
            @(negedge clk);
            #1;
         end
         @(posedge clk);
         #1 in_valid = 1'b0;
      end
      loading = 1'b0;
   endtask

   task automatic load_mat(input logic [2:0] op, input int seed);
      issue(op);
      loading = 1'b1;
      push_beats(op, seed);
   endtask

   task automatic queue_store();
      for (int n = 0; n < N; n++) begin
         exp_t e;
         e.d    = mc[n];
         e.last = (n == N-1);
         q.push_back(e);
      end
   endtask

   task automatic do_store(input string tag);
      cur_tag = tag;
      queue_store();
      issue(3'd2);
      while (q.size() != 0) @(negedge clk);
   endtask

   // Irregular backpressure on the output.
   initial forever begin
      @(posedge clk);
      #1;
      bp_cnt++;
      out_ready = (bp_cnt % 5 != 2) && (bp_cnt % 7 != 3);
   end

   // Monitor: a handshake happens at the next rising edge.
   initial forever begin
      @(negedge clk);
      if (out_valid && out_ready) begin
         if (q.size() == 0) begin
            chk(1'b0, "R4 unexpected beat", out_data, 32'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(out_data == e.d, cur_tag, out_data, e.d);
            chk(out_last == e.last, "R4 last flag", 32'(out_last), 32'(e.last));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int stall;
      for (int n = 0; n < N; n++) mc[n] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!in_ready && !out_valid, "R1 idle after reset",
          {30'd0, in_ready, out_valid}, 32'h0);

      // R1: C reads zero after reset; R4 exercised under backpressure.
      do_store("R1 reset C");

      // R3 / R6: first product with overflowing operands.
      load_mat(3'd0, 1);
      load_mat(3'd1, 2);
      @(negedge clk);
      chk(!in_ready, "R3 in_ready low after load", 32'(in_ready), 32'h0);
      issue(3'd4);
      model_mac();
      do_store("R6 product");

      // R7: second accumulate, then R8/R9 stall of a load behind it.
      issue(3'd4);
      model_mac();
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 3'd0;
      #1;
      stall = 0;
      while (!cmd_ready) begin
         stall++;
         @(negedge clk);
         #1;
      end
      chk(stall == K*K*K/P + 1, "R9 stall length", 32'(stall), 32'(K*K*K/P + 1));
      chk(stall > 0, "R8 load held during MAC", 32'(stall), 32'h1);
      @(posedge clk);
      #1 cmd_valid = 1'b0;
      loading = 1'b1;
      push_beats(3'd0, 3);
      do_store("R7 accumulate");

      // R5: clear while B loads; R8: MAC held during the load.
      fork
         load_mat(3'd1, 4);
         begin
            wait (loading);
            issue(3'd3);
            chk(loading, "R5 clear during load", 32'(loading), 32'h1);
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_op    = 3'd4;
            #1;
            chk(!cmd_ready && loading, "R8 MAC held during load",
                32'(cmd_ready), 32'h0);
            cmd_valid = 1'b0;
         end
      join
      for (int n = 0; n < N; n++) mc[n] = '0;
      do_store("R5 cleared");

      issue(3'd4);
      model_mac();
      do_store("R6 second product");

      // R8: clear held during a store, applied after it.
      cur_tag = "R8 store before clear";
      queue_store();
      issue(3'd2);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 3'd3;
      #1;
      chk(!cmd_ready, "R8 clear held during store", 32'(cmd_ready), 32'h0);
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      #1 cmd_valid = 1'b0;
      chk(q.size() == 0, "R8 store finished before clear", 32'(q.size()), 32'h0);
      for (int n = 0; n < N; n++) mc[n] = '0;
      do_store("R5 clear after store");

      // R2: reserved codes do nothing.
      issue(3'd4);
      model_mac();
      issue(3'd6);
      issue(3'd7);
      @(negedge clk);
      chk(!in_ready && !out_valid, "R2 reserved code idle",
          {30'd0, in_ready, out_valid}, 32'h0);
      do_store("R2 C unchanged");

      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule